// File: doc/BRIEF.md
# Successive Approximation Search Controller

This block runs the digital side of a successive-approximation converter. After a start request it searches one code bit per clock, beginning at the most significant bit. A one-hot marker register shows which bit is on trial. On each trial the marked bit is set in the code that drives an external DAC. One clock later the external comparator says whether the DAC level is above the sampled input. If it is, the trial bit is dropped. If not, the trial bit is kept. The marker then moves one place toward the LSB and the next lower bit is raised.

After the LSB has been decided, the final code is copied to a result register and a one-cycle completion pulse is given. The comparator input must be valid at the clock edge that follows each code update. A code of all ones in the marker's place order (MSB first) is the search order.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no start, `dac_code_o`, `trial_mark_o`, `result_o` and `done_o` are all zero.
- R2: A start sampled high while idle makes both `trial_mark_o` and `dac_code_o` equal to a 1 in bit WIDTH-1 and 0 elsewhere after that edge.
- R3: While a search runs, `trial_mark_o` has at most one bit set and moves one place toward bit 0 on each clock; it is zero once bit 0 has been decided.
- R4: When `cmp_hi_i` is 1 at a decision edge (1 means the DAC level is above the input), the bit marked by `trial_mark_o` is 0 in `dac_code_o` after that edge.
- R5: When `cmp_hi_i` is 0 at a decision edge, the marked bit stays 1 in `dac_code_o` after that edge.
- R6: After a decision on any bit other than bit 0, the next lower bit of `dac_code_o` is set to 1 and all higher, already decided bits keep their values.
- R7: `done_o` is high for exactly one cycle, starting after the WIDTH-th edge after the edge that accepted start. At that point `result_o` holds the final code.
- R8: A start that is high during a running search has no effect on the search in progress.
- R9: `result_o` changes only in the cycle in which `done_o` is high. It holds its value during a later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new search; used only while idle |
| cmp_hi_i | input | 1 | Comparator result: 1 when the DAC level is above the input |
| dac_code_o | output | WIDTH | Trial code driven to the DAC |
| trial_mark_o | output | WIDTH | One-hot marker of the bit under trial |
| result_o | output | WIDTH | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when `result_o` is fresh |

## Verification
Each result is due at a fixed edge. The marker and trial code change at the edge that accepts start and at every later edge. Each comparator decision shows in the code one edge after the code it judged was presented. The completion pulse and the new result appear WIDTH edges after the accepting edge.

The bench models the comparator as an ideal compare of the trial code against a chosen input level. A behavioural model advances at the same edges as the design. All outputs are compared at the falling clock edge, midway between updates, so each check reads the value settled after the edge under test. Input levels include the two midscale cases, the extremes and a pseudo-random sweep. There are also starts held high across a whole search and back-to-back searches.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  srch_state_t state_q, state_d;
  logic        done_q, done_d;

  assign load_o = (state_q == SRCH_IDLE) && start_i;
  assign step_o = (state_q == SRCH_RUN);
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (load_o) begin
      state_d = SRCH_RUN;
    end else if (step_o && last_i) begin
      state_d = SRCH_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SRCH_RUN) && !last_i |=> (state_q == SRCH_RUN));
endmodule

// File: rtl/sar_ptr.sv
module sar_ptr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] mark_o
);
  localparam logic [WIDTH-1:0] TOP_MARK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] mark_q, mark_d;
  logic             mark_en;

  assign mark_en = load_i || step_i;
  assign mark_o  = mark_q;

  always_comb begin
    if (load_i) mark_d = TOP_MARK;
    else        mark_d = mark_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mark_q <= '0;
    else if (mark_en) mark_q <= mark_d;
  end

  // R3
  mark_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mark_q));

  // R3
  mark_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> mark_q == ($past(mark_q) >> 1));

  // R2
  mark_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> mark_q == TOP_MARK);
endmodule

// File: rtl/sar_code.sv
module sar_code #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_hi_i,
  input  logic [WIDTH-1:0] mark_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_MARK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, code_d, kept;
  logic [WIDTH-1:0] res_q;
  logic             code_en, res_en;

  assign code_en  = load_i || step_i;
  assign res_en   = step_i && mark_i[0];
  assign code_o   = code_q;
  assign result_o = res_q;

  always_comb begin
    kept = cmp_hi_i ? (code_q & ~mark_i) : code_q;
    if (load_i) code_d = TOP_MARK;
    else        code_d = kept | (mark_i >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= kept;
  end

  // R4
  trial_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && cmp_hi_i |=> (code_q & $past(mark_i)) == '0);

  // R5
  trial_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !cmp_hi_i |=> (code_q & $past(mark_i)) == $past(mark_i));

  // R6
  next_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !mark_i[0] |=>
      ((code_q & ($past(mark_i) >> 1)) != '0) &&
      ((code_q & ~(($past(mark_i) << 1) - 1'b1)) ==
       ($past(code_q) & ~(($past(mark_i) << 1) - 1'b1))));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_i && mark_i[0]) |=> $stable(res_q));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] trial_mark_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  logic             load, step;
  logic [WIDTH-1:0] mark;

  sar_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .last_i  (mark[0]),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  sar_ptr #(.WIDTH(WIDTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .mark_o (mark)
  );

  sar_code #(.WIDTH(WIDTH)) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .cmp_hi_i (cmp_hi_i),
    .mark_i   (mark),
    .code_o   (dac_code_o),
    .result_o (result_o)
  );

  assign trial_mark_o = mark;

  // R7
  done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> trial_mark_o == '0);
endmodule

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         cmp_hi;
  logic [W-1:0] dac_code, mark, result;
  logic         done;
  int           vin;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           cmp_on = 0;

  always #5 clk = ~clk;

  assign cmp_hi = (int'(dac_code) > vin);

  sar_ctrl #(.WIDTH(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .cmp_hi_i     (cmp_hi),
    .dac_code_o   (dac_code),
    .trial_mark_o (mark),
    .result_o     (result),
    .done_o       (done)
  );

  // behavioural reference model
  int m_code, m_mark, m_bit, m_res;
  bit m_busy, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_mark = 0; m_bit = 0; m_res = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_bit = W - 1;
          m_mark = 1 << m_bit; m_code = m_mark;
        end
      end else begin
        if (m_code > vin) m_code = m_code & ~(1 << m_bit);
        if (m_bit == 0) begin
          m_busy = 0; m_mark = 0; m_res = m_code; m_done = 1;
        end else begin
          m_bit = m_bit - 1;
          m_mark = 1 << m_bit;
          m_code = m_code | m_mark;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R4 R5 R6 dac code", int'(dac_code), m_code);
      check("R2 R3 trial mark", int'(mark), m_mark);
      check("R7 done", int'(done), int'(m_done));
      check("R9 result", int'(result), m_res);
    end
  end

  task automatic convert(input int level, input int extra);
    @(negedge clk);
    vin = level; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + extra) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lfsr = 8'h5a;
    rst_n = 1'b0; start = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    // R1 outputs zero in reset
    check("R1 reset code", int'(dac_code), 0);
    check("R1 reset mark", int'(mark), 0);
    check("R1 reset result", int'(result), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (2) @(negedge clk);
    check("R1 idle code", int'(dac_code), 0);
    // R2 first trial is the top bit alone
    vin = 112; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 first code", int'(dac_code), 1 << (W - 1));
    repeat (W + 2) @(negedge clk);
    check("R7 low-half result", int'(result), 112);
    convert(208, 2);
    check("R7 high-half result", int'(result), 208);
    convert(0, 2);
    check("R4 all cleared", int'(result), 0);
    convert(255, 2);
    check("R5 all kept", int'(result), 255);
    convert(128, 1);
    convert(127, 0);
    // R8 start held high across whole searches, back to back
    @(negedge clk);
    vin = 77; start = 1'b1;
    repeat (3 * W + 5) @(negedge clk);
    vin = 33;
    repeat (2 * W) @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
    // R8 short start pulse mid search
    @(negedge clk);
    vin = 150; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
    check("R8 result after mid start", int'(result), 150);
    // R9 result holds while a new search runs
    for (int i = 0; i < 40; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hff;
      convert(lfsr, i % 3);
    end
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule